// File: doc/BRIEF.md
# Saturating Integer Element Unit

This unit takes one pair of integer operands per cycle, adds or subtracts them, and clamps the result to the range of the destination element width instead of letting it wrap. A sign-mode input selects signed or unsigned clamping. Separate width codes describe how the operands are read (source width) and how wide the result may be (destination width). The arithmetic is exact: no precision is lost before the clamp, so narrowing happens only through clamping.

Each result comes with a four-bit condition field. Three bits classify the clamped value against zero (less, greater, equal). The fourth bit reports whether the clamp changed the value. That bit describes only the current element and never accumulates across elements. If an operation that also needs a carry output is requested together with saturation, the unit flags it as illegal.

The datapath is combinational, followed by one register stage. An input valid strobe is returned as an output valid one cycle later. The result and condition registers load only on valid cycles.

Top module: `sat_elem_unit`

## Requirements
- R1: With `sign_mode`=0, the result is clamped to 0 .. 2^w-1 and zero-extended to 64 bits. Here w is the destination width selected by `dst_w`, coded 0=8, 1=16, 2=32, 3=64 bits.
- R2: With `sign_mode`=1, the result is clamped to -2^(w-1) .. 2^(w-1)-1 and sign-extended to 64 bits.
- R3: Each operand is read at the source width selected by `src_w` (same coding as `dst_w`), and its upper bits are ignored. Operands are sign-extended when `sign_mode`=1 and zero-extended otherwise. The add or subtract is exact at no less than the wider of the two widths, with no intermediate wrap.
- R4: `cond[0]` (overflow) is 1 exactly when clamping changed the value. A value equal to a range limit gives 0.
- R5: The overflow bit depends only on the current element. A saturating element does not raise it for any later element.
- R6: `illegal` is 1 for an element issued with `carry_req`=1, and 0 for every element issued with `carry_req`=0. The result of an illegal element is not defined.
- R7: `cond[3]`=lt, `cond[2]`=gt and `cond[1]`=eq classify the clamped result against zero: as a signed value when `sign_mode`=1, and as an unsigned value otherwise. For a legal element exactly one of the three is set, and lt is never set in unsigned mode.
- R8: `op_sub`=1 computes a-b; `op_sub`=0 computes a+b.
- R9: `out_valid` equals `in_valid` delayed by one cycle. `result`, `cond` and `illegal` change only one cycle after a cycle with `in_valid`=1.
- R10: After reset, `out_valid`, `result`, `cond` and `illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| in_valid | input | 1 | operands present this cycle |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| carry_req | input | 1 | operation also asks for a carry output (illegal with saturation) |
| sign_mode | input | 1 | 1 = signed clamp, 0 = unsigned clamp |
| src_w | input | 2 | source element width code |
| dst_w | input | 2 | destination element width code |
| opnd_a | input | 64 | first operand |
| opnd_b | input | 64 | second operand |
| out_valid | output | 1 | registered result present |
| result | output | 64 | clamped and extended result |
| cond | output | 4 | {lt, gt, eq, overflow} |
| illegal | output | 1 | carry-producing operation was requested |

## Verification
The assertions watch four properties on every cycle:
- the one-cycle valid latency;
- the illegal flag for carry-requesting elements;
- exactly one of lt, gt and eq set for each legal element, with lt never set in unsigned mode;
- the upper 56 bits of an unsigned 8-bit result staying zero.

The exact clamp values, the overflow bit on and next to the range limits, and the handling of mixed source and destination widths depend on operand values. Only the bench scenarios can show those. The same holds for the absence of any sticky overflow from one element to the next and for held outputs on idle cycles. The bench compares each of these against an independent model.

// File: rtl/sat_pkg.sv
package sat_pkg;

   typedef enum logic [1:0] {
      EW_8  = 2'd0,
      EW_16 = 2'd1,
      EW_32 = 2'd2,
      EW_64 = 2'd3
   } ew_e;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic ov;
   } cond_t;

   function automatic int ew_bits(input ew_e code);
      return 8 << code;
   endfunction

endpackage

// File: rtl/sat_opnd_ext.sv
module sat_opnd_ext
   import sat_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int GUARD = 2,
   localparam int IW   = XLEN + GUARD
) (
   input  logic [XLEN-1:0]      raw,
   input  ew_e                  width,
   input  logic                 sgn,
   output logic signed [IW-1:0] ext
);

   int                   shamt;
   logic [XLEN-1:0]      aligned;
   logic signed [IW-1:0] wide;

   // move the element's top bit to bit XLEN-1, then shift back with fill
   always_comb begin
      shamt   = XLEN - ew_bits(width);
      aligned = raw << shamt;
      wide    = sgn ? {{GUARD{aligned[XLEN-1]}}, aligned}
                    : {{GUARD{1'b0}}, aligned};
      ext     = wide >>> shamt;
   end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
   import sat_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int GUARD = 2,
   localparam int IW   = XLEN + GUARD
) (
   input  logic signed [IW-1:0] exact,
   input  ew_e                  width,
   input  logic                 sgn,
   output logic [XLEN-1:0]      clamped,
   output logic                 ov
);

   int                   wb;
   logic signed [IW-1:0] hi;
   logic signed [IW-1:0] lo;
   logic signed [IW-1:0] sel;

   always_comb begin
      wb = ew_bits(width);
      if (sgn) begin
         hi = $signed((IW'(1) << (wb - 1)) - IW'(1));
         lo = ~hi;
      end else begin
         hi = $signed((IW'(1) << wb) - IW'(1));
         lo = '0;
      end
      ov = 1'b1;
      if (exact > hi)      sel = hi;
      else if (exact < lo) sel = lo;
      else begin
         sel = exact;
         ov  = 1'b0;
      end
      // in-range value: its low XLEN bits are already the zero/sign extension
      clamped = sel[XLEN-1:0];
   end

endmodule

// File: rtl/sat_elem_unit.sv
module sat_elem_unit
   import sat_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int GUARD = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            op_sub,
   input  logic            carry_req,
   input  logic            sign_mode,
   input  logic [1:0]      src_w,
   input  logic [1:0]      dst_w,
   input  logic [XLEN-1:0] opnd_a,
   input  logic [XLEN-1:0] opnd_b,
   output logic            out_valid,
   output logic [XLEN-1:0] result,
   output logic [3:0]      cond,
   output logic            illegal
);

   localparam int IW = XLEN + GUARD;

   generate
      if (XLEN != (8 << 3)) begin : g_bad_xlen
         $error("XLEN must match the widest element code (64)");
      end
      if (GUARD < 2) begin : g_bad_guard
         $error("GUARD needs two bits for an exact 64-bit sum of extended operands");
      end
   endgenerate

   logic [XLEN-1:0]      raw_op [2];
   logic signed [IW-1:0] ext_op [2];
   logic signed [IW-1:0] exact;
   logic [XLEN-1:0]      clamped;
   logic                 ov;
   cond_t                cond_nx;

   assign raw_op[0] = opnd_a;
   assign raw_op[1] = opnd_b;

   generate
      for (genvar k = 0; k < 2; k++) begin : g_ext
         sat_opnd_ext #(.XLEN(XLEN), .GUARD(GUARD)) i_ext (
            .raw   (raw_op[k]),
            .width (ew_e'(src_w)),
            .sgn   (sign_mode),
            .ext   (ext_op[k])
         );
      end
   endgenerate

   assign exact = op_sub ? (ext_op[0] - ext_op[1]) : (ext_op[0] + ext_op[1]);

   sat_clamp #(.XLEN(XLEN), .GUARD(GUARD)) i_clamp (
      .exact   (exact),
      .width   (ew_e'(dst_w)),
      .sgn     (sign_mode),
      .clamped (clamped),
      .ov      (ov)
   );

   always_comb begin
      cond_nx.lt = sign_mode & clamped[XLEN-1];
      cond_nx.eq = (clamped == '0);
      cond_nx.gt = ~cond_nx.lt & ~cond_nx.eq;
      cond_nx.ov = ov;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         cond      <= '0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            illegal <= carry_req;
            result  <= carry_req ? '0 : clamped;
            cond    <= carry_req ? '0 : cond_nx;
         end
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid)) else $error("valid latency"); // R9

   AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (illegal == $past(carry_req))) else $error("illegal flag"); // R6

   AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !carry_req) |=> ($countones(cond[3:1]) == 1)) else $error("class bits"); // R7

   AST_UNS_NO_LT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !carry_req && !sign_mode) |=> !cond[3]) else $error("unsigned lt"); // R7

   AST_UNS8_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !carry_req && !sign_mode && dst_w == 2'd0) |=> (result[XLEN-1:8] == '0))
      else $error("unsigned 8-bit range"); // R1

endmodule

// File: tb/test_sat_elem_unit.sv
module test_sat_elem_unit;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct {
      logic [63:0] res;
      logic [3:0]  cnd;
      logic        ill;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        op_sub = 1'b0;
   logic        carry_req = 1'b0;
   logic        sign_mode = 1'b0;
   logic [1:0]  src_w = '0;
   logic [1:0]  dst_w = '0;
   logic [63:0] opnd_a = '0;
   logic [63:0] opnd_b = '0;
   logic        out_valid;
   logic [63:0] result;
   logic [3:0]  cond;
   logic        illegal;

   int    n_checks = 0;
   int    n_fail   = 0;
   int    cycles   = 0;
   bit    done     = 1'b0;
   exp_t  sb[$];
   logic [63:0] last_res = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sat_elem_unit i_sat_elem_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
      .carry_req(carry_req), .sign_mode(sign_mode), .src_w(src_w), .dst_w(dst_w),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result),
      .cond(cond), .illegal(illegal)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // independent reference: explicit bit loops and per-width limits
   function automatic exp_t model(input logic [63:0] a, input logic [63:0] b, input bit sub,
                                  input logic [1:0] sw, input logic [1:0] dw, input bit sg,
                                  input bit cy, input string tag);
      exp_t e;
      logic signed [67:0] ea, eb, v, hi, lo;
      int ws, wd;
      bit o;
      ws = 8 * (1 << sw);
      wd = 8 * (1 << dw);
      ea = '0; eb = '0;
      for (int i = 0; i < 68; i++) begin
         ea[i] = (i < ws) ? a[i] : (sg & a[ws-1]);
         eb[i] = (i < ws) ? b[i] : (sg & b[ws-1]);
      end
      v = sub ? ea - eb : ea + eb;
      if (sg) begin
         hi = (68'sd1 <<< (wd - 1)) - 68'sd1;
         lo = -hi - 68'sd1;
      end else begin
         hi = (68'sd1 <<< wd) - 68'sd1;
         lo = 68'sd0;
      end
      o = 1'b0;
      if (v > hi) begin v = hi; o = 1'b1; end
      if (v < lo) begin v = lo; o = 1'b1; end
      e.res = v[63:0];
      e.cnd = {(v < 0), (v > 0), (v == 0), o};
      e.ill = cy;
      e.tag = tag;
      if (cy) begin
         e.res = 'x;
         e.cnd = 'x;
      end
      return e;
   endfunction

   task automatic send(input logic [63:0] a, input logic [63:0] b, input bit sub,
                       input logic [1:0] sw, input logic [1:0] dw, input bit sg,
                       input bit cy, input string tag);
      exp_t e;
      @(negedge clk);
      opnd_a = a; opnd_b = b; op_sub = sub; src_w = sw; dst_w = dw;
      sign_mode = sg; carry_req = cy; in_valid = 1'b1;
      e = model(a, b, sub, sw, dw, sg, cy, tag);
      if (!cy) last_res = e.res;
      sb.push_back(e);
   endtask

   // R9: after an idle cycle the valid is low and the result is held
   task automatic idle_check();
      @(negedge clk);
      in_valid = 1'b0;
      opnd_a = 64'h1234; opnd_b = 64'h1;
      @(negedge clk);
      check(out_valid == 1'b0, "R9 valid low when idle", {63'd0, out_valid}, 64'd0);
      check(result == last_res, "R9 result held when idle", result, last_res);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R9 unexpected out_valid", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(illegal == e.ill, {e.tag, " illegal"}, {63'd0, illegal}, {63'd0, e.ill});
            if (!e.ill) begin
               check(result == e.res, {e.tag, " result"}, result, e.res);
               check(cond == e.cnd, {e.tag, " cond"}, {60'd0, cond}, {60'd0, e.cnd});
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         done = 1'b1;
         check(1'b0, "watchdog expired", 64'(cycles), 64'(WATCHDOG));
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      check(out_valid == 0 && result == 0 && cond == 0 && illegal == 0,
            "R10 reset state", result, 64'd0);
      rst_n = 1'b1;

      send(64'd10, 64'd20, 0, 2'd0, 2'd0, 0, 0, "R8 uns add");
      send(64'd30, 64'd12, 1, 2'd0, 2'd0, 0, 0, "R8 uns sub");
      send(64'd200, 64'd100, 0, 2'd0, 2'd0, 0, 0, "R1 uns8 clamp hi");
      send(64'd5, 64'd9, 1, 2'd1, 2'd1, 0, 0, "R1 uns16 clamp lo");
      send('1, 64'd1, 0, 2'd3, 2'd3, 0, 0, "R1 uns64 clamp hi");
      send(64'd100, 64'd100, 0, 2'd0, 2'd0, 1, 0, "R2 s8 clamp hi");
      send(64'h9C, 64'd100, 1, 2'd0, 2'd0, 1, 0, "R2 s8 clamp lo");
      send(64'hFFFF_FFFB, 64'd3, 0, 2'd2, 2'd2, 1, 0, "R2 s32 sign ext");
      send(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 2'd3, 2'd3, 1, 0, "R2 s64 clamp hi");
      send(64'h0100, 64'h0000, 0, 2'd1, 2'd0, 0, 0, "R3 src16 dst8 no wrap");
      send(64'hABCD_0005, 64'hFF03, 0, 2'd0, 2'd1, 0, 0, "R3 upper bits ignored");
      send(64'h80, 64'h80, 0, 2'd0, 2'd1, 1, 0, "R3 s8 to s16 wider");
      send(64'd255, 64'd0, 0, 2'd0, 2'd0, 0, 0, "R4 uns8 at limit");
      send(64'h7F, 64'd0, 0, 2'd0, 2'd0, 1, 0, "R4 s8 at limit");
      send(64'd250, 64'd250, 0, 2'd0, 2'd0, 0, 0, "R5 saturating first");
      send(64'd1, 64'd1, 0, 2'd0, 2'd0, 0, 0, "R5 no sticky ov");
      send(64'd1, 64'd1, 0, 2'd0, 2'd0, 0, 1, "R6 carry illegal");
      send(64'd3, 64'd2, 0, 2'd0, 2'd0, 0, 0, "R6 legal after illegal");
      send(64'd5, 64'd5, 1, 2'd2, 2'd2, 1, 0, "R7 eq");
      send(64'd2, 64'd7, 1, 2'd2, 2'd2, 1, 0, "R7 lt signed");
      send(64'hF0, 64'd0, 0, 2'd0, 2'd0, 0, 0, "R7 unsigned gt");
      idle_check();

      for (int n = 0; n < 80; n++) begin
         logic [63:0] ra, rb;
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         if (n % 3 == 0) ra = ra >> ($urandom % 64);
         send(ra, rb, 1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
              1'(($urandom % 10) == 0), "R3 random mix");
      end
      idle_check();

      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R9 all results returned", 64'(sb.size()), 64'd0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule